// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target-side handshake engine of a simple PCI slave. For each bus transaction it classifies the command as a configuration, I/O or memory access. It decides whether the device claims the access, and then drives the three target response signals. The access is completed with one data phase, refused with a retry while the device is busy, or cut down to a single data phase when the initiator tries to burst. The datapath, parity, the serial EEPROM engine and all register contents live elsewhere. This block only sees a hit indication, the two enable bits of the command register and a few event strobes.

Two conditions make the device busy. The first is the configuration preload from the serial EEPROM. It is active from reset release until the loader reports completion, and software can restart it. The second is a short internal soft-reset window, started by a read of the reset register and timed by a down-counter of `SRST_CLKS` bus clocks (33 for a 33 MHz bus). All bus control pins are shown here as active-high: a port value of 1 means the corresponding low-true bus signal is asserted.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is held and in the first cycle after it, `devsel`, `trdy` and `stop` are 0, and the preload busy condition is active from reset release.
- R2: Command decode. `cmd` 4'b1010/4'b1011 is configuration, claimed when `addr_hit` is 1. 4'b0010/4'b0011 is I/O, claimed only when `addr_hit` and `io_en` are 1. 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111 are memory, claimed only when `addr_hit` and `mem_en` are 1. All other codes are never claimed. An unclaimed access never drives `devsel`, `trdy` or `stop`.
- R3: If the first edge sampling `frame`=1 in idle is edge A, the claimed response (`devsel` with `trdy` or `stop`) appears at edge A+1 and not earlier.
- R4: While preload is busy, every claimed access is answered with `devsel`=1, `stop`=1, `trdy`=0, and no data phase completes.
- R5: A one-cycle `preload_req` makes preload busy from the next cycle. A `preload_done` pulse clears it from the next cycle.
- R6: Once `stop` is asserted, it stays asserted until an edge samples `frame`=0 and `irdy`=0.
- R7: A one-cycle `rst_reg_rd` opens a soft-reset window of `SRST_CLKS` clocks. I/O and memory accesses decided inside the window get a retry (as R4). Configuration accesses are served normally. After the window, I/O is served normally again.
- R8: If `frame`=1 and `irdy`=1 are sampled at edge A+1, `trdy` and `stop` rise together at that edge and exactly one data phase completes.
- R9: If a data phase completes while `frame` is still 1, `stop` is asserted at the next edge, so a burst that started with host wait states also ends after one transfer.
- R10: On a normal single access, `trdy` is held until `irdy` is sampled 1, exactly one data phase completes, and `trdy` drops at the transfer edge.
- R11: At the first edge sampling `frame`=0 and `irdy`=0 after a response, all three outputs go to 0 and the block accepts a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI bus clock |
| rst_n | input | 1 | Hardware reset, active low |
| frame | input | 1 | Initiator cycle framing, 1 = asserted |
| irdy | input | 1 | Initiator ready, 1 = asserted |
| cmd | input | 4 | Bus command sampled in the address phase |
| addr_hit | input | 1 | Address or select decode hit for this device |
| io_en | input | 1 | I/O space enable bit of the command register |
| mem_en | input | 1 | Memory space enable bit of the command register |
| preload_req | input | 1 | Software request to rerun the EEPROM preload |
| preload_done | input | 1 | EEPROM preload has finished |
| rst_reg_rd | input | 1 | Strobe: the reset register was read |
| devsel | output | 1 | Device select, 1 = asserted |
| trdy | output | 1 | Target ready, 1 = asserted |
| stop | output | 1 | Target stop request, 1 = asserted |

## Verification
The first response of a claimed access is due one edge after the edge that samples the address phase. The bench drives inputs just after a rising edge and samples outputs at the following falling edge, so the first sample after edge A must show all zeros and the next must show the response code. A completed data phase is counted at the falling edge before the edge that consumes it, whenever `trdy` and `irdy` are both 1 there. The initiator model changes `frame` and `irdy` only after the following rising edge, and the release of all outputs is checked exactly one sample after the edge that first sees both inputs low. The busy conditions take effect one edge after their strobes, and each access is timed well inside or well outside the soft-reset window.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_CFG  = 2'd1,
        SP_IO   = 2'd2,
        SP_MEM  = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECIDE = 3'd1,
        ST_XFER   = 3'd2,
        ST_HOLD   = 3'd3,
        ST_IGNORE = 3'd4
    } tstate_e;

    typedef struct packed {
        tstate_e st;
        space_e  sp;
        logic    devsel;
        logic    trdy;
        logic    stop;
    } tgt_regs_t;

    localparam tgt_regs_t TGT_RESET = '{st: ST_IDLE, sp: SP_NONE,
                                        devsel: 1'b0, trdy: 1'b0, stop: 1'b0};

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int CMD_W = 4
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             addr_hit,
    input  logic             io_en,
    input  logic             mem_en,
    output space_e           space,
    output logic             claim
);

    always_comb begin
        unique case (cmd)
            CMD_W'(4'b1010), CMD_W'(4'b1011):                    space = SP_CFG;
            CMD_W'(4'b0010), CMD_W'(4'b0011):                    space = SP_IO;
            CMD_W'(4'b0110), CMD_W'(4'b0111), CMD_W'(4'b1100),
            CMD_W'(4'b1110), CMD_W'(4'b1111):                    space = SP_MEM;
            default:                                             space = SP_NONE;
        endcase
    end

    always_comb begin
        unique case (space)
            SP_CFG:  claim = addr_hit;
            SP_IO:   claim = addr_hit && io_en;
            SP_MEM:  claim = addr_hit && mem_en;
            default: claim = 1'b0;
        endcase
    end

    // R2: a claim always needs a hit and a known space
    always_comb begin
        a_r2_claim_needs_hit: assert (!(claim && !addr_hit));
        a_r2_claim_needs_space: assert (!(claim && space == SP_NONE));
    end

endmodule

// File: rtl/pci_tgt_busy.sv
module pci_tgt_busy #(
    parameter int SRST_CLKS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic preload_req,
    input  logic preload_done,
    input  logic rst_reg_rd,
    output logic preload_busy,
    output logic srst_busy
);

    localparam int CNT_W = $clog2(SRST_CLKS + 1);

    typedef struct packed {
        logic             preload;
        logic [CNT_W-1:0] cnt;
    } busy_regs_t;

    busy_regs_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (preload_req)
            b_d.preload = 1'b1;
        else if (preload_done)
            b_d.preload = 1'b0;

        if (rst_reg_rd)
            b_d.cnt = CNT_W'(SRST_CLKS);
        else if (b_q.cnt != '0)
            b_d.cnt = b_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            b_q <= '{preload: 1'b1, cnt: '0};
        else
            b_q <= b_d;
    end

    assign preload_busy = b_q.preload;
    assign srst_busy    = (b_q.cnt != '0);

    a_r5_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        preload_req |=> preload_busy);
    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_done && !preload_req) |=> !preload_busy);
    a_r7_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        rst_reg_rd |=> srst_busy);

endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame,
    input  logic   irdy,
    input  space_e space,
    input  logic   claim,
    input  logic   preload_busy,
    input  logic   srst_busy,
    output logic   devsel,
    output logic   trdy,
    output logic   stop
);

    tgt_regs_t r_d, r_q;
    logic      retry;
    logic      bus_idle;

    always_comb begin
        r_d      = r_q;
        retry    = preload_busy || (srst_busy && r_q.sp != SP_CFG);
        bus_idle = !frame && !irdy;
        unique case (r_q.st)
            ST_IDLE: begin
                if (frame) begin
                    r_d.sp = space;
                    r_d.st = claim ? ST_DECIDE : ST_IGNORE;
                end
            end
            ST_DECIDE: begin
                r_d.devsel = 1'b1;
                if (retry) begin
                    r_d.trdy = 1'b0;
                    r_d.stop = 1'b1;
                    r_d.st   = ST_HOLD;
                end else begin
                    r_d.trdy = 1'b1;
                    r_d.stop = frame && irdy;
                    r_d.st   = ST_XFER;
                end
            end
            ST_XFER: begin
                if (bus_idle) begin
                    r_d = TGT_RESET;
                end else if (irdy) begin
                    r_d.trdy = 1'b0;
                    if (frame)
                        r_d.stop = 1'b1;
                    r_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (bus_idle)
                    r_d = TGT_RESET;
            end
            ST_IGNORE: begin
                if (bus_idle)
                    r_d = TGT_RESET;
            end
            default: r_d = TGT_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= TGT_RESET;
        else
            r_q <= r_d;
    end

    assign devsel = r_q.devsel;
    assign trdy   = r_q.trdy;
    assign stop   = r_q.stop;

    a_r3_no_early_claim: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && frame) |=> (!devsel && !trdy && !stop));
    a_r3_medium_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DECIDE) |=> (devsel && (trdy || stop)));
    a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && frame && !claim) |=> (!devsel && !trdy && !stop));
    a_r4_preload_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DECIDE && preload_busy) |=> (stop && !trdy));
    a_r7_srst_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DECIDE && srst_busy && r_q.sp == SP_IO) |=> (stop && !trdy));
    a_r6_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && (frame || irdy)) |=> stop);
    a_r8_burst_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DECIDE && !retry && frame && irdy) |=> (trdy && stop));
    a_r9_stop_after_burst_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && irdy && frame) |=> stop);
    a_r10_trdy_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && !irdy && frame) |=> trdy);
    a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && irdy) |=> !trdy);
    a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel && !frame && !irdy) |=> (!devsel && !trdy && !stop));

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
    import pci_tgt_pkg::*;
#(
    parameter int SRST_CLKS = 33,
    parameter int CMD_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic [CMD_W-1:0] cmd,
    input  logic             addr_hit,
    input  logic             io_en,
    input  logic             mem_en,
    input  logic             preload_req,
    input  logic             preload_done,
    input  logic             rst_reg_rd,
    output logic             devsel,
    output logic             trdy,
    output logic             stop
);

    space_e space;
    logic   claim;
    logic   preload_busy;
    logic   srst_busy;

    pci_tgt_decode #(.CMD_W(CMD_W)) i_decode (
        .cmd      (cmd),
        .addr_hit (addr_hit),
        .io_en    (io_en),
        .mem_en   (mem_en),
        .space    (space),
        .claim    (claim)
    );

    pci_tgt_busy #(.SRST_CLKS(SRST_CLKS)) i_busy (
        .clk          (clk),
        .rst_n        (rst_n),
        .preload_req  (preload_req),
        .preload_done (preload_done),
        .rst_reg_rd   (rst_reg_rd),
        .preload_busy (preload_busy),
        .srst_busy    (srst_busy)
    );

    pci_tgt_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame        (frame),
        .irdy         (irdy),
        .space        (space),
        .claim        (claim),
        .preload_busy (preload_busy),
        .srst_busy    (srst_busy),
        .devsel       (devsel),
        .trdy         (trdy),
        .stop         (stop)
    );

    a_r1_trdy_has_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy || stop) |-> devsel);

endmodule

// File: tb/test_pci_tgt_term.sv
module test_pci_tgt_term;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0, irdy = 1'b0;
    logic [3:0] cmd = 4'b0000;
    logic       addr_hit = 1'b0, io_en = 1'b0, mem_en = 1'b0;
    logic       preload_req = 1'b0, preload_done = 1'b0, rst_reg_rd = 1'b0;
    logic       devsel, trdy, stop;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pci_tgt_term i_pci_tgt_term (
        .clk(clk), .rst_n(rst_n), .frame(frame), .irdy(irdy), .cmd(cmd),
        .addr_hit(addr_hit), .io_en(io_en), .mem_en(mem_en),
        .preload_req(preload_req), .preload_done(preload_done),
        .rst_reg_rd(rst_reg_rd), .devsel(devsel), .trdy(trdy), .stop(stop)
    );

    typedef struct {
        logic [2:0] first;
        int         xfers;
        bit         any;
        bit         stop_seen;
        bit         early_drop;
        bit         released;
        bit         premature;
        string      tag;
    } res_t;

    res_t exp_q[$];
    res_t obs_q[$];

    localparam logic [2:0] RSP_NONE   = 3'b000;
    localparam logic [2:0] RSP_RETRY  = 3'b101;
    localparam logic [2:0] RSP_NORMAL = 3'b110;
    localparam logic [2:0] RSP_CUT    = 3'b111;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic pulse_req();
        @(posedge clk); #1 preload_req = 1'b1;
        @(posedge clk); #1 preload_req = 1'b0;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1 preload_done = 1'b1;
        @(posedge clk); #1 preload_done = 1'b0;
    endtask

    task automatic pulse_rst_rd();
        @(posedge clk); #1 rst_reg_rd = 1'b1;
        @(posedge clk); #1 rst_reg_rd = 1'b0;
    endtask

    // driver: pushes the expected result, runs one transaction as initiator
    task automatic run_txn(input logic [3:0] c, input bit hit, input bit burst,
                           input bit hwait, input logic [2:0] rsp,
                           input bit host_wait_stop, input string tag);
        res_t e, o;
        bit   nf, ni;
        int   end_i;
        e.first      = rsp;
        e.xfers      = (rsp == RSP_NORMAL || rsp == RSP_CUT) ? 1 : 0;
        e.any        = (rsp != RSP_NONE);
        e.stop_seen  = (rsp == RSP_RETRY || rsp == RSP_CUT || host_wait_stop);
        e.early_drop = 1'b0;
        e.released   = 1'b1;
        e.premature  = 1'b0;
        e.tag        = tag;
        exp_q.push_back(e);

        o = '{first: 3'b000, xfers: 0, any: 1'b0, stop_seen: 1'b0,
              early_drop: 1'b0, released: 1'b0, premature: 1'b0, tag: tag};
        @(posedge clk); #1;
        frame = 1'b1; irdy = 1'b0; cmd = c; addr_hit = hit;
        @(posedge clk); #1;          // edge A sampled the address phase
        frame = burst; irdy = !hwait; cmd = 4'b0000; addr_hit = 1'b0;
        @(negedge clk);
        o.premature = devsel || trdy || stop;
        nf = frame; ni = irdy; end_i = 0;
        for (int i = 1; i < 16; i++) begin
            @(posedge clk); #1;
            frame = nf; irdy = ni;
            if (end_i == 0 && !nf && !ni) end_i = i;
            @(negedge clk);
            if (i == 1) o.first = {devsel, trdy, stop};
            if (end_i != 0 && i == end_i + 1) begin
                o.released = !(devsel || trdy || stop);
                break;
            end
            if (devsel || trdy || stop) o.any = 1'b1;
            if (o.stop_seen && !stop) o.early_drop = 1'b1;
            if (stop) o.stop_seen = 1'b1;
            if (trdy && irdy) o.xfers++;
            if (end_i == 0) begin
                if (!devsel && i >= 3) begin
                    nf = 1'b0; ni = 1'b0;          // master abort
                end else if (devsel) begin
                    if (stop) begin
                        if (frame) nf = 1'b0; else ni = 1'b0;
                    end else if (trdy && irdy) begin
                        if (!frame) ni = 1'b0;
                    end else if (!irdy) begin
                        ni = 1'b1;
                    end
                end
            end
        end
        obs_q.push_back(o);
    endtask

    // monitor: pops expected and observed results and compares them
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0 && exp_q.size() != 0) begin
                res_t e, o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                chk(e.tag, "R3 first response d/t/s", int'(o.first), int'(e.first));
                chk(e.tag, "R3 nothing before A+1", int'(o.premature), int'(e.premature));
                chk(e.tag, "R2 drove any output", int'(o.any), int'(e.any));
                chk(e.tag, "R10 data phases", o.xfers, e.xfers);
                chk(e.tag, "R9 stop seen", int'(o.stop_seen), int'(e.stop_seen));
                chk(e.tag, "R6 stop dropped early", int'(o.early_drop), int'(e.early_drop));
                chk(e.tag, "R11 released after idle", int'(o.released), int'(e.released));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 in reset", "devsel", int'(devsel), 0);
        chk("R1 in reset", "trdy|stop", int'(trdy || stop), 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", "outputs", int'({devsel, trdy, stop}), 0);

        // preload busy from reset release
        run_txn(4'b1010, 1, 0, 0, RSP_RETRY, 0, "R4 R1 cfg read during post-reset preload");
        run_txn(4'b0010, 1, 0, 0, RSP_NONE,  0, "R2 io read disabled during preload");
        pulse_done();
        run_txn(4'b1010, 1, 0, 0, RSP_NORMAL, 0, "R5 R10 cfg read after preload done");

        // claim rules
        run_txn(4'b0010, 1, 0, 0, RSP_NONE, 0, "R2 io read with io_en=0");
        io_en = 1'b1;
        run_txn(4'b0011, 1, 0, 0, RSP_NORMAL, 0, "R2 R10 io write with io_en=1");
        run_txn(4'b0111, 1, 0, 0, RSP_NONE, 0, "R2 mem write with mem_en=0");
        run_txn(4'b1010, 0, 0, 0, RSP_NONE, 0, "R2 cfg read without hit");
        run_txn(4'b0000, 1, 0, 0, RSP_NONE, 0, "R2 unsupported command code");
        mem_en = 1'b1;

        // soft-reset window
        pulse_rst_rd();
        run_txn(4'b0010, 1, 0, 0, RSP_RETRY,  0, "R7 io read inside soft-reset window");
        run_txn(4'b1011, 1, 0, 0, RSP_NORMAL, 0, "R7 cfg write inside soft-reset window");
        run_txn(4'b0110, 1, 0, 0, RSP_RETRY,  0, "R7 mem read inside soft-reset window");
        repeat (40) @(posedge clk);
        run_txn(4'b0010, 1, 0, 0, RSP_NORMAL, 0, "R7 io read after soft-reset window");

        // bursts
        run_txn(4'b0110, 1, 1, 0, RSP_CUT,    0, "R8 R11 zero-wait mem burst");
        run_txn(4'b1010, 1, 1, 1, RSP_NORMAL, 1, "R9 cfg burst with host wait");
        run_txn(4'b0010, 1, 1, 0, RSP_CUT,    0, "R8 zero-wait io burst");

        // software-started preload
        pulse_req();
        run_txn(4'b0111, 1, 1, 0, RSP_RETRY, 0, "R5 R4 R6 mem burst during software preload");
        run_txn(4'b0010, 1, 0, 0, RSP_RETRY, 0, "R5 R4 io read during software preload");
        pulse_done();
        run_txn(4'b1010, 1, 0, 0, RSP_NORMAL, 0, "R5 R11 cfg read after second preload");

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule